// File: doc/BRIEF.md
# Dual Counter Timer with Shared Match Interrupts

This peripheral holds two independent 16-bit counters. Each counter has its own load value, prescale divider and control register. A bank of six compare registers is shared by both counters. Each compare register drives one bit of a small interrupt unit. The unit has sticky status bits, a per-bit mask and a single interrupt line.

Software loads a counter and picks its direction. It then chooses where the counter ends:
- reaching zero,
- reaching one chosen compare register, or
- never (free-running).

A counter that reaches its end point freezes and sets its own stop flag, so one-shot events can be built from it. A free-running counter works as a plain timebase.

All registers sit behind a simple synchronous write / combinational read port. The port uses byte addresses on 32-bit words.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every value, divider, compare, mask and status register reads 0, both control registers read 0x10 (stopped), and `irq_o` is 0.
- R2: The byte address map is as follows:
  - Counter 0: value at 0x00, divider at 0x04, control at 0x08.
  - Counter 1: value at 0x0C, divider at 0x10, control at 0x14.
  - Compare register n: 0x18+4·n, for n = 0..5.
  - Status at 0x30. Writing 1s to 0x30 clears bits.
  - Mask at 0x34.
  - Unmapped addresses read 0.
- R3: The control register fields are:
  - bit 4: 1 = stopped.
  - bit 3: 1 = count up, 0 = count down.
  - bits 2:0 = end mode.

  With mode 0 a running counter moves toward zero. When it reaches zero it holds there and bit 4 becomes 1.
- R4: With divider D, a running counter takes one step every D+1 clocks. D = 0 means one step on every clock.
- R5: A write to a control register restarts that counter's prescaler. The first step after the write comes D+1 clocks later.
- R6: Mode m in 1..6 makes compare register m−1 the end point. On reaching that value the counter holds and sets bit 4 of its control register.
- R7: Mode 7 runs forever, and the value wraps modulo 2^16 (0xFFFE counting up gives 0xFFFF, 0x0000, 0x0001).
- R8: While bit 4 of its control register is 1, a counter keeps its value.
- R9: A counter started with mode 0 while already at 0 stops at once without stepping.
- R10: Status bit n (bits 5:0) is set whenever either running counter steps onto the value of compare register n. Several bits can be set by one step.
- R11: `irq_o` is the OR of (status AND mask). Status reads back unmasked.
- R12: Writing to 0x30 clears exactly the status bits written as 1. Bits written as 0 are unchanged.
- R13: A counter's value register accepts any 16-bit load, including 0xFFFF, and counts down from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default 16-bit counter and 16-bit divider widths. With these widths the wrap from 0xFFFF to 0x0000 can be reached in a few cycles by loading near the top of the range. Small divider values (2 and 3) expose the step spacing and the prescaler restart within a dozen clocks. Because every compare register except one holds zero, a single wrap through zero sets several status bits in one step. The remaining compare register is used for a masked versus unmasked one-shot.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned CTL_W = 5;
  localparam logic [2:0] MODE_ZERO = 3'd0;
  localparam logic [2:0] MODE_FREE = 3'd7;

  typedef struct packed {
    logic       stop;
    logic       up;
    logic [2:0] mode;
  } ctl_t;
endpackage

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned NUM_MATCH = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 val_we_i,
  input  logic                 div_we_i,
  input  logic                 ctl_we_i,
  input  logic [CNT_W-1:0]     val_wdata_i,
  input  logic [DIV_W-1:0]     div_wdata_i,
  input  ctl_t                 ctl_wdata_i,
  input  logic [CNT_W-1:0]     match_i [NUM_MATCH],
  output logic [CNT_W-1:0]     cnt_o,
  output logic [DIV_W-1:0]     div_o,
  output ctl_t                 ctl_o,
  output logic                 step_o,
  output logic [CNT_W-1:0]     next_o
);
  logic [CNT_W-1:0] cnt_q, nxt, tgt;
  logic [DIV_W-1:0] div_q, psc_q;
  ctl_t             ctl_q;
  logic             tick, has_tgt, at_tgt, step, hit;

  assign tick = !ctl_q.stop && (psc_q >= div_q);
  assign nxt  = ctl_q.up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

  always_comb begin
    has_tgt = 1'b1;
    tgt     = '0;
    if (ctl_q.mode == MODE_FREE) begin
      has_tgt = 1'b0;
    end else if (ctl_q.mode != MODE_ZERO) begin
      has_tgt = 1'b0;
      for (int n = 0; n < NUM_MATCH; n++) begin
        if (int'(ctl_q.mode) == n + 1) begin
          has_tgt = 1'b1;
          tgt     = match_i[n];
        end
      end
    end
  end

  assign at_tgt = has_tgt && (cnt_q == tgt);
  assign step   = tick && !at_tgt;
  assign hit    = step && has_tgt && (nxt == tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
      psc_q <= '0;
      ctl_q <= '{stop: 1'b1, up: 1'b0, mode: MODE_ZERO};
    end else begin
      if (div_we_i) div_q <= div_wdata_i;

      if (ctl_we_i)        psc_q <= '0;
      else if (tick)       psc_q <= '0;
      else if (!ctl_q.stop) psc_q <= psc_q + DIV_W'(1);

      if (val_we_i)  cnt_q <= val_wdata_i;
      else if (step) cnt_q <= nxt;

      if (ctl_we_i)                   ctl_q      <= ctl_wdata_i;
      else if (tick && (at_tgt || hit)) ctl_q.stop <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign div_o  = div_q;
  assign ctl_o  = ctl_q;
  assign step_o = step && !val_we_i;
  assign next_o = nxt;

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.stop && !val_we_i) |=> $stable(cnt_q));

  // R3 R6
  tgt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && has_tgt && cnt_q == tgt && !ctl_we_i) |=> ctl_q.stop);

  // R7
  free_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ctl_q.mode == MODE_FREE && !val_we_i)
      |=> cnt_q == ($past(ctl_q.up) ? $past(cnt_q) + CNT_W'(1) : $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] status_q, mask_q, clr;

  assign clr = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr) | set_i;  // new events win over a clear
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  // R12
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(clr_i & ~set_i)) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

  // R10
  set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned NUM_TMR   = 2;
  localparam int unsigned NUM_MATCH = 6;
  localparam int unsigned REGS_TMR  = 3;
  localparam int unsigned MATCH_W0  = NUM_TMR * REGS_TMR;
  localparam int unsigned STAT_W0   = MATCH_W0 + NUM_MATCH;
  localparam int unsigned MASK_W0   = STAT_W0 + 1;
  localparam int unsigned WORD_W    = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr;
  logic [CNT_W-1:0]  match_q [NUM_MATCH];
  logic [CNT_W-1:0]  cnt     [NUM_TMR];
  logic [DIV_W-1:0]  div     [NUM_TMR];
  ctl_t              ctl     [NUM_TMR];
  logic [CNT_W-1:0]  nxt     [NUM_TMR];
  logic [NUM_TMR-1:0] step;
  logic [NUM_MATCH-1:0] set, status, mask;
  logic unused_bits;

  assign word = addr_i[ADDR_W-1:2];
  assign wr   = req_i && we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CNT_W]};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dmt_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W), .NUM_MATCH(NUM_MATCH)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .val_we_i    (wr && int'(word) == t * REGS_TMR),
      .div_we_i    (wr && int'(word) == t * REGS_TMR + 1),
      .ctl_we_i    (wr && int'(word) == t * REGS_TMR + 2),
      .val_wdata_i (wdata_i[CNT_W-1:0]),
      .div_wdata_i (wdata_i[DIV_W-1:0]),
      .ctl_wdata_i (ctl_t'(wdata_i[CTL_W-1:0])),
      .match_i     (match_q),
      .cnt_o       (cnt[t]),
      .div_o       (div[t]),
      .ctl_o       (ctl[t]),
      .step_o      (step[t]),
      .next_o      (nxt[t])
    );
  end

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_match
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  match_q[n] <= '0;
      else if (wr && int'(word) == MATCH_W0 + n)    match_q[n] <= wdata_i[CNT_W-1:0];
    end

    always_comb begin
      set[n] = 1'b0;
      for (int t = 0; t < NUM_TMR; t++)
        if (step[t] && nxt[t] == match_q[n]) set[n] = 1'b1;
    end
  end

  dmt_irq #(.NUM_SRC(NUM_MATCH)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set),
    .clr_we_i     (wr && int'(word) == STAT_W0),
    .clr_i        (wdata_i[NUM_MATCH-1:0]),
    .mask_we_i    (wr && int'(word) == MASK_W0),
    .mask_wdata_i (wdata_i[NUM_MATCH-1:0]),
    .status_o     (status),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (int'(word) == t * REGS_TMR)     rdata_o = DATA_W'(cnt[t]);
      if (int'(word) == t * REGS_TMR + 1) rdata_o = DATA_W'(div[t]);
      if (int'(word) == t * REGS_TMR + 2) rdata_o = DATA_W'(ctl[t]);
    end
    for (int n = 0; n < NUM_MATCH; n++)
      if (int'(word) == MATCH_W0 + n) rdata_o = DATA_W'(match_q[n]);
    if (int'(word) == STAT_W0) rdata_o = DATA_W'(status);
    if (int'(word) == MASK_W0) rdata_o = DATA_W'(mask);
  end

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status & mask) != '0);
endmodule

// File: tb/dual_match_timer_test.sv
`timescale 1ns/1ps
module dual_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
    bit          on_irq;
  } item_t;
  item_t sb_q[$];
  event  smp;

  always #10 clk = ~clk;

  dual_match_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(smp);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.on_irq ? {31'b0, irq} : rdata;
        vectors++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(string tag, logic [5:0] a, logic [31:0] e);
    addr = a;
    sb_q.push_back('{tag, e, 1'b0});
    #1 -> smp;
    #1;
  endtask

  task automatic rd_irq(string tag, logic e);
    sb_q.push_back('{tag, {31'b0, e}, 1'b1});
    #1 -> smp;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd("R1 value0", 6'h00, 0); rd("R1 ctl0", 6'h08, 32'h10); rd("R1 ctl1", 6'h14, 32'h10);
    tick(1);
    rd("R1 status", 6'h30, 0); rd("R1 mask", 6'h34, 0); rd_irq("R1 irq", 1'b0);
    tick(1);
    rd("R1 match0", 6'h18, 0); rd("R1 div1", 6'h10, 0); rd("R2 unmapped", 6'h38, 0);

    // R3 count down to zero and stop
    wr(6'h00, 10);
    wr(6'h08, 32'h00);
    tick(4);  rd("R3 value after 4", 6'h00, 6);
    tick(6);  rd("R3 value at zero", 6'h00, 0); rd("R3 stop set", 6'h08, 32'h10);
    tick(3);  rd("R3 hold zero", 6'h00, 0);

    // R13 full-range load, down count; R8 stopped counter holds
    wr(6'h00, 32'hFFFF);
    wr(6'h08, 32'h00);
    tick(5);  rd("R13 value", 6'h00, 32'hFFFA);
    wr(6'h08, 32'h10);
    rd("R8 value at stop", 6'h00, 32'hFFF9);
    tick(4);  rd("R8 value held", 6'h00, 32'hFFF9);

    // R9 start at target
    wr(6'h00, 0);
    wr(6'h08, 32'h00);
    tick(2);  rd("R9 value", 6'h00, 0); rd("R9 stop", 6'h08, 32'h10);

    // R6 compare end point, R10/R11 status and irq
    wr(6'h20, 32'h20);
    wr(6'h34, 32'h04);
    wr(6'h30, 32'h3F);
    wr(6'h00, 32'h1C);
    wr(6'h08, 32'h0B);
    tick(3);  rd("R6 before match", 6'h00, 32'h1F); rd_irq("R11 irq low", 1'b0);
    tick(1);  rd("R6 at match", 6'h00, 32'h20); rd("R6 stop", 6'h08, 32'h1B); rd("R10 status", 6'h30, 32'h04);
    tick(2);  rd_irq("R11 irq high", 1'b1); rd("R6 held", 6'h00, 32'h20); rd("R2 match2", 6'h20, 32'h20);

    // R11 mask gates irq, status visible
    wr(6'h34, 0);
    rd_irq("R11 masked irq", 1'b0); rd("R11 raw status", 6'h30, 32'h04);
    wr(6'h34, 32'h04);
    rd_irq("R11 unmasked irq", 1'b1);

    // R12 write-one-to-clear
    wr(6'h30, 32'h01);
    rd("R12 zero bits kept", 6'h30, 32'h04);
    wr(6'h30, 32'h04);
    rd("R12 cleared", 6'h30, 0); rd_irq("R12 irq low", 1'b0);

    // R4 divider on counter 1
    wr(6'h0C, 0);
    wr(6'h10, 2);
    wr(6'h14, 32'h0F);
    tick(9);  rd("R4 three steps", 6'h0C, 3); rd("R2 div1", 6'h10, 2);
    tick(1);  rd("R4 between steps", 6'h0C, 3);
    tick(2);  rd("R4 fourth step", 6'h0C, 4);

    // R5 prescaler restart
    wr(6'h14, 32'h10);
    wr(6'h0C, 0);
    wr(6'h10, 3);
    wr(6'h14, 32'h0F);
    tick(1);
    wr(6'h14, 32'h0F);
    tick(3);  rd("R5 no step yet", 6'h0C, 0);
    tick(1);  rd("R5 first step", 6'h0C, 1);

    // R7 wrap; R10 several bits from one step
    wr(6'h14, 32'h10);
    wr(6'h30, 32'h3F);
    wr(6'h0C, 32'hFFFE);
    wr(6'h10, 0);
    wr(6'h14, 32'h0F);
    tick(3);  rd("R7 wrapped", 6'h0C, 1); rd("R10 multi status", 6'h30, 32'h3B); rd("R7 running", 6'h14, 32'h0F);
    tick(1);  rd_irq("R11 masked multi", 1'b0);

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule